// File: doc/BRIEF.md
# Dual-Mode Serial Clock Edge Generator

This block produces the rising-edge and falling-edge ticks that a serial-peripheral transfer engine uses to shift data. It runs entirely on the module clock and makes no clock of its own. A one-cycle pulse marks each place where the serial clock would change level. The period comes from a 32-bit control word that holds two divisor fields and a scheme select bit. The linear scheme gives a serial period of 2·(N+1) module cycles. The exponential scheme gives a serial period of 2^M module cycles.

The ticks run only while the transfer engine holds `burst_active` high. The first tick of every burst is a rising tick, and the two kinds then alternate. The block copies the divisor into an internal half-period register when a burst starts and again each time a falling tick is issued. This means a change to the control word never shortens or stretches a serial clock period that is already in progress.

The control logic is a three-state machine. **IDLE**: no burst is active and no ticks are issued. The transition *start* (burst seen high) loads the half-period and moves to LOW. **LOW**: the serial clock is low. The transition *rise* (half-period elapsed) issues a rising tick and moves to HIGH. **HIGH**: the serial clock is high. The transition *fall* (half-period elapsed) issues a falling tick, reloads the half-period and returns to LOW. From LOW or HIGH, the transition *abort* (burst seen low) returns to IDLE.

Top module: `spi_sclk_divider`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sclk_rise` and `sclk_fall` are both low.
- R2: In any cycle that follows a clock edge at which `burst_active` was low, neither tick is asserted.
- R3: When `clk_ctl[12]` is 1 (linear scheme), consecutive ticks are N+1 module cycles apart, where N = `clk_ctl[7:0]`. The first tick comes N+2 cycles after the edge at which `burst_active` is first seen high.
- R4: When `clk_ctl[12]` is 0 (exponential scheme), with M = `clk_ctl[11:8]` and M ≥ 1, ticks are 2^(M-1) module cycles apart, so the full serial period is 2^M.
- R5: Linear N=0, exponential M=0 and exponential M=1 each give a tick on every module cycle.
- R6: The first tick of a burst is a rising tick, and after that rising and falling ticks strictly alternate.
- R7: `sclk_rise` and `sclk_fall` are never high in the same cycle.
- R8: A new divisor or scheme value takes effect only from the first rising tick after a falling tick. The low and high halves of any one serial period are always equal in length.
- R9: Bits 31:13 of `clk_ctl` have no effect on the tick timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ctl | input | 32 | Clock control word: linear divisor [7:0], exponential divisor [11:8], scheme select [12] |
| burst_active | input | 1 | High while the transfer engine wants serial clock edges |
| sclk_rise | output | 1 | One-cycle pulse marking a serial clock rising edge |
| sclk_fall | output | 1 | One-cycle pulse marking a serial clock falling edge |

## Verification
The properties assume that `burst_active` stays low through reset. They also assume that the control word is only rewritten in a way that lets the period-boundary reload happen. Equal halves are checked against whatever half-period was loaded, so the control word may change at any cycle, including in the middle of a half-period. The stimulus holds the burst low through reset. It applies control changes on the falling edge of the module clock at chosen points: in the low half, exactly on a rising tick, and between bursts. It drops the burst on a tick cycle so that the abort path is exercised.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } sclk_phase_e;

endpackage

// File: rtl/sclk_half_decode.sv
module sclk_half_decode #(
    parameter int CTL_W    = 32,
    parameter int LIN_W    = 8,
    parameter int LIN_LSB  = 0,
    parameter int EXP_W    = 4,
    parameter int EXP_LSB  = 8,
    parameter int MODE_BIT = 12,
    parameter int CNT_W    = 15
) (
    input  logic [CTL_W-1:0] ctl,
    output logic [CNT_W-1:0] half_len
);

    logic [LIN_W-1:0] lin_n;
    logic [EXP_W-1:0] exp_m;

    assign lin_n = ctl[LIN_LSB +: LIN_W];
    assign exp_m = ctl[EXP_LSB +: EXP_W];

    // Half-period in module cycles for the selected scheme.
    always_comb begin
        if (ctl[MODE_BIT]) begin
            half_len = CNT_W'(lin_n) + CNT_W'(1);
        end else if (exp_m <= EXP_W'(1)) begin
            half_len = CNT_W'(1);
        end else begin
            half_len = CNT_W'(1) << (exp_m - EXP_W'(1));
        end
    end

endmodule

// File: rtl/sclk_edge_fsm.sv
module sclk_edge_fsm
    import sclk_div_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half_len,
    output logic             rise_tick,
    output logic             fall_tick
);

    sclk_phase_e      state;
    sclk_phase_e      nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_q;
    logic             half_done;

    assign half_done = (cnt == half_q - CNT_W'(1));

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions: start, rise, fall, abort.
    always_comb begin
        nxt = state;
        unique case (state)
            PH_IDLE: nxt = run ? PH_LOW : PH_IDLE;
            PH_LOW: begin
                if (!run)           nxt = PH_IDLE;
                else if (half_done) nxt = PH_HIGH;
            end
            PH_HIGH: begin
                if (!run)           nxt = PH_IDLE;
                else if (half_done) nxt = PH_LOW;
            end
            default: nxt = PH_IDLE;
        endcase
    end

    // Half-period counter; the divisor is captured only at start or after a fall.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            half_q <= CNT_W'(1);
        end else if (!run) begin
            cnt <= '0;
        end else if (state == PH_IDLE) begin
            cnt    <= '0;
            half_q <= half_len;
        end else if (half_done) begin
            cnt <= '0;
            if (state == PH_HIGH) begin
                half_q <= half_len;
            end
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Registered tick outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_tick <= 1'b0;
            fall_tick <= 1'b0;
        end else begin
            rise_tick <= run && (state == PH_LOW)  && half_done;
            fall_tick <= run && (state == PH_HIGH) && half_done;
        end
    end

endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider #(
    parameter int CTL_W    = 32,
    parameter int LIN_W    = 8,
    parameter int LIN_LSB  = 0,
    parameter int EXP_W    = 4,
    parameter int EXP_LSB  = 8,
    parameter int MODE_BIT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] clk_ctl,
    input  logic             burst_active,
    output logic             sclk_rise,
    output logic             sclk_fall
);

    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int CNT_W   = (LIN_W + 1 > EXP_MAX) ? LIN_W + 1 : EXP_MAX;

    logic [CNT_W-1:0] half_len;

    sclk_half_decode #(
        .CTL_W   (CTL_W),
        .LIN_W   (LIN_W),
        .LIN_LSB (LIN_LSB),
        .EXP_W   (EXP_W),
        .EXP_LSB (EXP_LSB),
        .MODE_BIT(MODE_BIT),
        .CNT_W   (CNT_W)
    ) u_decode (
        .ctl     (clk_ctl),
        .half_len(half_len)
    );

    sclk_edge_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (burst_active),
        .half_len (half_len),
        .rise_tick(sclk_rise),
        .fall_tick(sclk_fall)
    );

endmodule

// File: rtl/spi_sclk_divider_chk.sv
module spi_sclk_divider_chk #(
    parameter int CNT_W = 15
) (
    input logic clk,
    input logic rst_n,
    input logic burst_active,
    input logic sclk_rise,
    input logic sclk_fall
);

    localparam int GW = CNT_W + 1;

    logic [GW-1:0] gap;
    logic [GW-1:0] rise_gap;
    logic          armed;
    logic          last_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap       <= '1;
            rise_gap  <= '0;
            armed     <= 1'b0;
            last_rise <= 1'b0;
        end else if (!burst_active) begin
            gap       <= '1;
            armed     <= 1'b0;
            last_rise <= 1'b0;
        end else begin
            if (sclk_rise || sclk_fall) gap <= GW'(1);
            else                        gap <= gap + GW'(1);
            if (sclk_rise) begin
                rise_gap  <= gap;
                armed     <= 1'b1;
                last_rise <= 1'b1;
            end else if (sclk_fall) begin
                armed     <= 1'b0;
                last_rise <= 1'b0;
            end
        end
    end

    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_rise && sclk_fall));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!burst_active) |-> (!sclk_rise && !sclk_fall));

    a_r6_rise_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |-> !last_rise);

    a_r6_fall_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_fall |-> last_rise);

    a_r8_equal_halves: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall && armed && burst_active) |-> (gap == rise_gap));

endmodule

bind spi_sclk_divider spi_sclk_divider_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_active(burst_active),
    .sclk_rise   (sclk_rise),
    .sclk_fall   (sclk_fall)
);

// File: tb/spi_sclk_divider_test.sv
module spi_sclk_divider_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] clk_ctl = 32'h0;
    logic        burst_active = 1'b0;
    logic        sclk_rise;
    logic        sclk_fall;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_sclk_divider uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_ctl     (clk_ctl),
        .burst_active(burst_active),
        .sclk_rise   (sclk_rise),
        .sclk_fall   (sclk_fall)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    function automatic logic [31:0] lin_cfg(input int n);
        return 32'h0000_1000 | 32'(n & 8'hFF);
    endfunction

    function automatic logic [31:0] exp_cfg(input int m);
        return 32'((m & 4'hF) << 8);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one burst. gaps[0] is the number of negedges from the start to the
    // first tick; gaps[i] is the spacing before tick i. Optionally rewrites the
    // control word at negedge chg_at.
    task automatic run_burst(input logic [31:0] cfg0, input int chg_at,
                             input logic [31:0] cfg1, input int k,
                             input int gaps[8], input string req);
        int  next_n;
        int  got;
        int  limit;
        bit  want_rise;
        int  quiet;
        clk_ctl   = cfg0;
        burst_active = 1'b1;
        next_n    = gaps[0];
        got       = 0;
        want_rise = 1'b1;
        limit = 0;
        for (int i = 0; i < k; i++) limit += gaps[i];
        limit += 10;
        for (int n = 1; n <= limit; n++) begin
            @(negedge clk);
            if (sclk_rise || sclk_fall) begin
                check(!(sclk_rise && sclk_fall), "R7 both ticks", 1, 0);
                check(n == next_n, {req, " tick position"}, n, next_n);
                check(sclk_rise == want_rise, "R6 tick kind (1=rise)", int'(sclk_rise), int'(want_rise));
                want_rise = !want_rise;
                got++;
                if (got < k) next_n += gaps[got];
            end else if (n > next_n) begin
                check(1'b0, {req, " missing tick"}, n, next_n);
                got = k;
            end
            if (n == chg_at) clk_ctl = cfg1;
            if (got >= k) break;
        end
        burst_active = 1'b0;
        quiet = 0;
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            if (sclk_rise || sclk_fall) quiet++;
        end
        check(quiet == 0, "R2 ticks after burst dropped", quiet, 0);
    endtask

    task automatic run_fixed(input logic [31:0] cfg, input int h, input string req);
        int g[8];
        g[0] = h + 1;
        for (int i = 1; i < 8; i++) g[i] = h;
        run_burst(cfg, -1, cfg, 4, g, req);
    endtask

    task automatic test_reset;
        check(!sclk_rise && !sclk_fall, "R1 ticks in reset", int'(sclk_rise | sclk_fall), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sclk_rise && !sclk_fall, "R1 ticks after reset", int'(sclk_rise | sclk_fall), 0);
    endtask

    task automatic test_idle;
        int seen;
        seen = 0;
        clk_ctl = lin_cfg(0);
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (sclk_rise || sclk_fall) seen++;
        end
        check(seen == 0, "R2 ticks with burst idle", seen, 0);
    endtask

    task automatic test_linear;
        run_fixed(lin_cfg(2), 3, "R3 linear N=2");
        run_fixed(lin_cfg(9), 10, "R3 linear N=9");
        run_fixed(lin_cfg(255), 256, "R3 linear N=255");
    endtask

    task automatic test_exponential;
        run_fixed(exp_cfg(3), 4, "R4 exponential M=3");
        run_fixed(exp_cfg(5), 16, "R4 exponential M=5");
        run_fixed(exp_cfg(2), 2, "R4 exponential M=2");
    endtask

    task automatic test_fastest;
        run_fixed(lin_cfg(0), 1, "R5 linear N=0");
        run_fixed(exp_cfg(0), 1, "R5 exponential M=0");
        run_fixed(exp_cfg(1), 1, "R5 exponential M=1");
    endtask

    task automatic test_change_on_rise;
        int g[8];
        g = '{5, 4, 1, 1, 1, 1, 1, 1};
        run_burst(lin_cfg(3), 5, lin_cfg(0), 4, g, "R8 change at rising tick");
    endtask

    task automatic test_change_in_low;
        int g[8];
        g = '{3, 2, 5, 5, 5, 5, 5, 5};
        run_burst(lin_cfg(1), 1, lin_cfg(4), 4, g, "R8 change in low half");
    endtask

    task automatic test_mode_switch;
        int g[8];
        g = '{3, 2, 8, 8, 8, 8, 8, 8};
        run_burst(lin_cfg(1), 3, exp_cfg(4), 4, g, "R8 scheme switch");
    endtask

    task automatic test_upper_bits;
        run_fixed(32'hFFFF_E000 | lin_cfg(2), 3, "R9 upper bits set linear");
        run_fixed(32'hFFFF_E000 | exp_cfg(3), 4, "R9 upper bits set exponential");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_idle();
        test_linear();
        test_exponential();
        test_fastest();
        test_change_on_rise();
        test_change_in_low();
        test_mode_switch();
        test_upper_bits();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule